// File: doc/BRIEF.md
# Soft-Start Zero-Sequence Offset Generator

This block supplies the zero-sequence offset that a carrier-based three-phase modulator adds to its scaled phase references. During start-up the offset is not formed from the usual min/max rule. It comes from a split ratio `dz`, the share of each period's zero-vector time spent with all three legs high (all-high time divided by all-high plus all-low time). The ratio starts at zero, so almost every zero interval uses the all-low state. It then climbs in programmable steps, one step per switching period, up to one half. This raises the average common-mode voltage gently instead of in one jump, so the resonance of a common-mode output filter is not excited when modulation begins.

The offset is `2*dz - 1 - dz*max(a,b,c) + (dz - 1)*min(a,b,c)`. At `dz = 0.5` this is plain symmetrical min/max injection. While the start input is low the block holds `dz` at zero internally and drives the `dz = 0.5` offset, so the modulator runs normally. Raising start restarts the ramp from zero. A done flag reports that the ramp has reached one half.

References and the offset are signed Q2.14 words (16384 is 1.0). `dz` is an unsigned word with 15 fractional bits (16384 is 0.5).

Top module: `zsr_soft_start`

## Requirements
- R1: While reset is asserted and on the first sample after it, `dz_o` is 0, `done_o` is 0 and `offset_o` is 0.
- R2: While `start_i` is low, `offset_o` equals the formula evaluated at `dz` = 16384 (0.5). When the largest and smallest references are both even, this is exactly -(max+min)/2 before clamping. `carrier_peak_i` pulses leave `dz_o` at 0.
- R3: While `start_i` is high, each clock with `carrier_peak_i` high adds `step_i` to `dz_o`. A clock without it leaves `dz_o` unchanged.
- R4: `dz_o` never exceeds 16384. A step that would pass it lands exactly on 16384.
- R5: `done_o` is high exactly when `start_i` is high and `dz_o` equals 16384.
- R6: `offset_o` is registered one clock after its inputs. Its value is (dz - 16384) - rnd(dz*max) + rnd((dz - 32768)*min), where rnd(p) adds 2^14 and then arithmetic-shifts right by 15.
- R7: With all three references zero, `offset_o` equals 2*dz - 1, which is `dz_o` - 16384 in output units.
- R8: `offset_o` is clamped to the range -16384 to +16384.
- R9: Lowering `start_i` clears `dz_o` and `done_o` on the next clock. Raising it again restarts the ramp from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | High: run or hold the ramp. Low: idle with symmetrical injection |
| carrier_peak_i | input | 1 | One-clock pulse at each carrier peak |
| step_i | input | 16 | Ramp increment per period, unsigned, 15 fractional bits |
| ref_a_i | input | 16 | Phase A scaled reference, signed Q2.14 |
| ref_b_i | input | 16 | Phase B scaled reference, signed Q2.14 |
| ref_c_i | input | 16 | Phase C scaled reference, signed Q2.14 |
| offset_o | output | 16 | Zero-sequence offset, signed Q2.14, clamped to ±1.0 |
| dz_o | output | 16 | Current all-high zero-vector split ratio |
| done_o | output | 1 | Ramp has reached 0.5 |

## Verification
The bench goes after the ends of the ramp. At `dz = 0` with zero references the offset must be exactly -1.0; an off-by-one in the `2dz - 1` term shows up there. A step size that does not divide 0.5 evenly must land exactly on 0.5 rather than wrap past it or stop short; a missing clamp would also leave done low for good. Idle operation is checked against hand-derived symmetrical injection, including odd references where a poorly placed rounding point would be off by one LSB. Extreme references drive the sum beyond ±1.0 to expose a missing or one-sided clamp. Ticks while idle, and a drop and raise of start, must show no leftover ramp state.

// File: rtl/zsr_pkg.sv
package zsr_pkg;
   // Clamp a wide signed value into [-lim, +lim]
   function automatic longint sat_sym(input longint v, input longint lim);
      if (v > lim)       return lim;
      else if (v < -lim) return -lim;
      else               return v;
   endfunction
endpackage

// File: rtl/zsr_extremes.sv
module zsr_extremes #(
   parameter int REF_W = 16
) (
   input  logic signed [REF_W-1:0] a_i,
   input  logic signed [REF_W-1:0] b_i,
   input  logic signed [REF_W-1:0] c_i,
   output logic signed [REF_W-1:0] max_o,
   output logic signed [REF_W-1:0] min_o
);
   logic signed [REF_W-1:0] hi_ab, lo_ab;

   always_comb begin
      hi_ab = (a_i > b_i) ? a_i : b_i;
      lo_ab = (a_i > b_i) ? b_i : a_i;
      max_o = (hi_ab > c_i) ? hi_ab : c_i;
      min_o = (lo_ab < c_i) ? lo_ab : c_i;
   end
endmodule

// File: rtl/zsr_split_ramp.sv
module zsr_split_ramp #(
   parameter int DZ_FRAC = 15
) (
   input  logic                clk_i,
   input  logic                rst_n_i,
   input  logic                run_i,
   input  logic                tick_i,
   input  logic [DZ_FRAC:0]    step_i,
   output logic [DZ_FRAC:0]    dz_o,
   output logic                at_top_o
);
   localparam int DZ_W = DZ_FRAC + 1;
   localparam logic [DZ_W-1:0] TOP = DZ_W'(1) << (DZ_FRAC - 1);

   logic [DZ_W-1:0] dz_q;
   logic [DZ_W:0]   nxt;

   assign nxt = {1'b0, dz_q} + {1'b0, step_i};

   always_ff @(posedge clk_i) begin
      if (!rst_n_i || !run_i) begin
         dz_q <= '0;
      end else if (tick_i) begin
         if (nxt > {1'b0, TOP}) dz_q <= TOP;
         else                   dz_q <= nxt[DZ_W-1:0];
      end
   end

   assign dz_o     = dz_q;
   assign at_top_o = (dz_q == TOP);
endmodule

// File: rtl/zsr_offset_calc.sv
module zsr_offset_calc #(
   parameter int REF_W   = 16,
   parameter int DZ_FRAC = 15,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_n_i,
   input  logic [DZ_FRAC:0]        dz_i,
   input  logic signed [REF_W-1:0] max_i,
   input  logic signed [REF_W-1:0] min_i,
   output logic signed [REF_W-1:0] offset_o
);
   import zsr_pkg::*;
   localparam int DZ_W  = DZ_FRAC + 1;
   localparam int ACC_W = REF_W + DZ_W + 4;
   localparam int R_FRAC = DZ_FRAC - 1;
   localparam logic signed [ACC_W-1:0] ONE   = ACC_W'(1) << R_FRAC;
   localparam logic signed [ACC_W-1:0] FULL  = ACC_W'(1) << DZ_FRAC;
   localparam logic signed [ACC_W-1:0] RHALF = ACC_W'(1) << (DZ_FRAC - 1);

   logic signed [ACC_W-1:0] dz_s, mx_s, mn_s, p_hi, p_lo, r_hi, r_lo, sum;
   logic signed [REF_W-1:0] sat_val;

   always_comb begin
      dz_s = {{(ACC_W-DZ_W){1'b0}}, dz_i};
      mx_s = {{(ACC_W-REF_W){max_i[REF_W-1]}}, max_i};
      mn_s = {{(ACC_W-REF_W){min_i[REF_W-1]}}, min_i};
      p_hi = dz_s * mx_s;
      p_lo = (dz_s - FULL) * mn_s;
      r_hi = (p_hi + RHALF) >>> DZ_FRAC;
      r_lo = (p_lo + RHALF) >>> DZ_FRAC;
      sum  = (dz_s - ONE) - r_hi + r_lo;
      sat_val = REF_W'(sat_sym(longint'(sum), longint'(ONE)));
   end

   generate
      if (OUT_REG) begin : g_reg
         logic signed [REF_W-1:0] off_q;
         always_ff @(posedge clk_i) begin
            if (!rst_n_i) off_q <= '0;
            else          off_q <= sat_val;
         end
         assign offset_o = off_q;
      end else begin : g_comb
         assign offset_o = sat_val;
      end
   endgenerate
endmodule

// File: rtl/zsr_soft_start.sv
module zsr_soft_start #(
   parameter int REF_W   = 16,
   parameter int DZ_FRAC = 15,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_n_i,
   input  logic                    start_i,
   input  logic                    carrier_peak_i,
   input  logic [DZ_FRAC:0]        step_i,
   input  logic signed [REF_W-1:0] ref_a_i,
   input  logic signed [REF_W-1:0] ref_b_i,
   input  logic signed [REF_W-1:0] ref_c_i,
   output logic signed [REF_W-1:0] offset_o,
   output logic [DZ_FRAC:0]        dz_o,
   output logic                    done_o
);
   localparam int DZ_W = DZ_FRAC + 1;
   localparam logic [DZ_W-1:0] DZ_HALF = DZ_W'(1) << (DZ_FRAC - 1);

   generate
      if (DZ_FRAC != REF_W - 1) begin : g_bad_frac
         $error("DZ_FRAC must equal REF_W-1 so that 2*dz maps onto the reference scale");
      end
      if (REF_W < 4) begin : g_bad_w
         $error("REF_W too small");
      end
   endgenerate

   logic signed [REF_W-1:0] ref_max, ref_min;
   logic [DZ_W-1:0]         dz_ramp, dz_eff;
   logic                    at_top;

   zsr_extremes #(.REF_W(REF_W)) ext_i (
      .a_i(ref_a_i), .b_i(ref_b_i), .c_i(ref_c_i),
      .max_o(ref_max), .min_o(ref_min)
   );

   zsr_split_ramp #(.DZ_FRAC(DZ_FRAC)) ramp_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .run_i(start_i),
      .tick_i(carrier_peak_i), .step_i(step_i),
      .dz_o(dz_ramp), .at_top_o(at_top)
   );

   // Idle: symmetrical injection, identical to a completed ramp
   assign dz_eff = start_i ? dz_ramp : DZ_HALF;

   zsr_offset_calc #(.REF_W(REF_W), .DZ_FRAC(DZ_FRAC), .OUT_REG(OUT_REG)) calc_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .dz_i(dz_eff),
      .max_i(ref_max), .min_i(ref_min), .offset_o(offset_o)
   );

   assign dz_o   = dz_ramp;
   assign done_o = start_i && at_top;
endmodule

// File: rtl/zsr_soft_start_chk.sv
module zsr_soft_start_chk #(
   parameter int REF_W   = 16,
   parameter int DZ_FRAC = 15
) (
   input logic                    clk_i,
   input logic                    rst_n_i,
   input logic                    start_i,
   input logic                    carrier_peak_i,
   input logic [DZ_FRAC:0]        step_i,
   input logic signed [REF_W-1:0] offset_o,
   input logic [DZ_FRAC:0]        dz_o,
   input logic                    done_o
);
   localparam int DZ_W = DZ_FRAC + 1;
   localparam logic [DZ_W-1:0] TOP = DZ_W'(1) << (DZ_FRAC - 1);
   localparam int ONE = 1 << (REF_W - 2);

   logic [DZ_W:0] sum_w;
   assign sum_w = {1'b0, dz_o} + {1'b0, step_i};

   AST_DZ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      dz_o <= TOP);                                                          // R4
   AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !start_i |=> dz_o == '0);                                              // R9
   AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && !carrier_peak_i) |=> dz_o == $past(dz_o));                 // R3
   AST_STEP_ADD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && carrier_peak_i && sum_w <= {1'b0, TOP})
         |=> dz_o == $past(dz_o) + $past(step_i));                           // R3
   AST_STEP_SAT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && carrier_peak_i && sum_w > {1'b0, TOP}) |=> dz_o == TOP);   // R4
   AST_DONE_VALID: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |-> (start_i && dz_o == TOP));                                  // R5
   AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (int'(offset_o) <= ONE) && (int'(offset_o) >= -ONE));                  // R8
endmodule

bind zsr_soft_start zsr_soft_start_chk #(.REF_W(REF_W), .DZ_FRAC(DZ_FRAC)) chk_i (
   .clk_i(clk_i), .rst_n_i(rst_n_i), .start_i(start_i),
   .carrier_peak_i(carrier_peak_i), .step_i(step_i),
   .offset_o(offset_o), .dz_o(dz_o), .done_o(done_o)
);

// File: tb/zsr_soft_start_tb_top.sv
module zsr_soft_start_tb_top;
   localparam int NV = 9;
   // ref a, ref b, ref c, expected idle offset (hand-derived -(max+min)/2, clamped)
   localparam int VEC [NV][4] = '{
      '{0, 0, 0, 0},
      '{8192, -4096, -4096, -2048},
      '{16384, -8192, -8192, -4096},
      '{2000, 6000, -10000, 2000},
      '{-12000, -2000, 4000, 4000},
      '{32000, -32000, 0, 0},
      '{32000, 30000, 31000, -16384},
      '{-32000, -30000, -31000, 16384},
      '{100, 100, 100, -100}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
   logic [15:0] step = '0;
   logic signed [15:0] ra = '0, rb = '0, rc = '0;
   logic signed [15:0] offset;
   logic [15:0] dz;
   logic done;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   zsr_soft_start dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .carrier_peak_i(tick),
      .step_i(step), .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
      .offset_o(offset), .dz_o(dz), .done_o(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_refs(input int a, input int b, input int c);
      ra = 16'(a); rb = 16'(b); rc = 16'(c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 dz in reset", int'(dz), 0);
      chk("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 dz after reset", int'(dz), 0);
      chk("R1 offset after reset", int'(offset), 0);

      // R2 / R8: idle symmetrical injection from the vector table
      for (int i = 0; i < NV; i++) begin
         set_refs(VEC[i][0], VEC[i][1], VEC[i][2]);
         @(negedge clk);
         chk($sformatf("R2 idle vector %0d", i), int'(offset), VEC[i][3]);
      end

      // R6: odd references, rounding of both products
      set_refs(1, 1, 1);
      @(negedge clk);
      chk("R6 odd rounding", int'(offset), -1);

      // R2: carrier peaks while idle change nothing
      set_refs(8192, -4096, -4096);
      step = 16'd4096;
      @(negedge clk);
      pulse();
      chk("R2 idle tick dz", int'(dz), 0);
      chk("R2 idle tick done", int'(done), 0);
      chk("R2 idle tick offset", int'(offset), -2048);

      // R7 / R3 / R4 / R5: ramp with zero references
      set_refs(0, 0, 0);
      start = 1'b1;
      @(negedge clk);
      chk("R7 dz=0 offset", int'(offset), -16384);
      chk("R5 done low at start", int'(done), 0);
      for (int k = 1; k <= 4; k++) begin
         pulse();
         chk($sformatf("R3 dz step %0d", k), int'(dz), 4096 * k);
         chk($sformatf("R7 offset step %0d", k), int'(offset), 4096 * k - 16384);
         chk($sformatf("R5 done step %0d", k), int'(done), (k == 4) ? 1 : 0);
      end
      pulse();
      chk("R4 hold at top", int'(dz), 16384);
      repeat (3) @(negedge clk);
      chk("R3 no tick hold", int'(dz), 16384);

      // R9: drop start
      start = 1'b0;
      @(negedge clk);
      chk("R9 dz cleared", int'(dz), 0);
      chk("R9 done cleared", int'(done), 0);
      chk("R9 idle offset", int'(offset), 0);

      // R4: step that does not divide 0.5
      step = 16'd5000;
      start = 1'b1;
      @(negedge clk);
      chk("R9 restart from zero", int'(dz), 0);
      pulse(); chk("R3 uneven 1", int'(dz), 5000);
      pulse(); chk("R3 uneven 2", int'(dz), 10000);
      pulse(); chk("R3 uneven 3", int'(dz), 15000);
      pulse(); chk("R4 uneven lands on top", int'(dz), 16384);
      chk("R5 uneven done", int'(done), 1);

      // R6: nonzero references during the ramp
      start = 1'b0;
      @(negedge clk);
      step = 16'd8192;
      set_refs(8192, 0, -8192);
      start = 1'b1;
      @(negedge clk);
      chk("R6 dz=0 refs", int'(offset), -8192);
      pulse();
      chk("R6 dz=0.25 refs", int'(offset), -4096);

      // R8: low clamp at dz=0.25 with large positive refs, then at dz=0
      set_refs(16000, 16000, 16000);
      @(negedge clk);
      chk("R8 low clamp", int'(offset), -16384);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1;
      set_refs(4000, 4000, 4000);
      @(negedge clk);
      chk("R8 clamp at dz=0", int'(offset), -16384);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule